// File: doc/BRIEF.md
# Windowed Feature Non-Max Suppressor

This block thins out a frame's worth of detected image features so that each small cluster of touching detections keeps only its strongest member. While idle, the block appends each feature it receives (an x coordinate, a y coordinate and a strength score) to an internal buffer. The first write after a frame goes to index 0, and the order of arrival is the detection order, row by row. A one-cycle start pulse marks the end of the frame. From then on the block walks the buffer from index 0 upward and emits one keep/drop flag per stored feature.

Two features touch when their x coordinates and their y coordinates each differ by no more than one. A feature is kept unless a touching feature beats it. A touching feature beats it when it has a strictly higher score, or an equal score and a lower buffer index. Features arrive in raster order, so any touching feature lies close by in the buffer. The search for each feature therefore covers only the entries at most `WIN` positions away from it, one candidate per clock. After the last flag the block pulses done and is ready to accept the next frame.

Top module: `feat_nms`

## Requirements
- R1: After reset, `flagValid` and `done` are low and the buffer holds no features.
- R2: Stored features produce no flags until a start pulse arrives while the block is idle.
- R3: Two features are neighbours exactly when |x1-x2| <= 1 and |y1-y2| <= 1. A feature with no neighbour in its search range is flagged kept (`flagKeep` = 1).
- R4: A feature that has a neighbour with a strictly higher score is flagged dropped (`flagKeep` = 0). The highest-scoring feature of a group is flagged kept.
- R5: When neighbouring features have equal scores, the one at the lower buffer index wins, so exactly one of them is kept.
- R6: For the feature at index i, only indices max(0, i-WIN) to min(N-1, i+WIN) are examined (WIN = 20 by default). A neighbour further away in the buffer has no effect on the flag.
- R7: A frame of N features yields exactly N flags. The flags come in ascending index order, 0 to N-1, and `flagIdx` equals the position at which the feature was written.
- R8: `done` pulses for one cycle, exactly one cycle after the last flag. A frame with no features gives no flags and still pulses `done`.
- R9: The buffer ignores a write while a frame is being scanned and a write in the same cycle as start. Each new frame begins again at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Append one feature to the buffer (idle only) |
| wrX | input | XW (10) | Feature x coordinate |
| wrY | input | YW (10) | Feature y coordinate |
| wrScore | input | SW (32) | Feature strength score, unsigned |
| start | input | 1 | End-of-frame pulse that begins the scan |
| flagValid | output | 1 | A flag is presented this cycle |
| flagIdx | output | $clog2(DEPTH) | Buffer index the flag belongs to |
| flagKeep | output | 1 | 1 = feature kept, 0 = suppressed |
| done | output | 1 | One-cycle pulse after the last flag of a frame |

## Verification
The checker keeps its own count of accepted writes and of emitted flags. To do so it assumes that `start` and `wrEn` are sampled as plain single-cycle strobes. It also assumes that a write is accepted only when no scan is running, `start` is low, and fewer than `DEPTH` features are stored. It treats the cycle in which `done` is high as idle. The stimulus drives every input at the falling edge and never raises `start` and `wrEn` together. It keeps every frame well below the buffer depth, and it makes exactly one write during a scan, on purpose, to show that the write is dropped.

// File: rtl/feat_nms_pkg.sv
package feat_nms_pkg;

  parameter int XW = 10;
  parameter int YW = 10;
  parameter int SW = 32;

  typedef struct packed {
    logic [SW-1:0] score;
    logic [YW-1:0] y;
    logic [XW-1:0] x;
  } feat_t;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic wr;    // append the write-port feature
    logic load;  // latch the centre feature
    logic cmp;   // compare one candidate this cycle
    logic last;  // this compare closes the centre's window
  } nms_strb_t;

endpackage

// File: rtl/feat_nms_ctrl.sv
module feat_nms_ctrl
  import feat_nms_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int WIN   = 20,
  parameter int IW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          start,
  output nms_strb_t     strb,
  output logic [IW-1:0] wrIdx,
  output logic [IW-1:0] cenIdx,
  output logic [IW-1:0] candIdx,
  output logic          done
);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_CMP, S_FIN} state_t;

  localparam logic [IW-1:0] WIN_I   = IW'(WIN);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  state_t        state;
  logic [CW-1:0] wrCnt;
  logic [IW-1:0] lastIdx;
  logic [IW-1:0] cen;
  logic [IW-1:0] cand;
  logic [IW-1:0] hi;
  logic [IW-1:0] loNext;
  logic [IW-1:0] hiNext;
  logic          atHi;

  always_comb begin
    atHi      = (cand == hi);
    strb.wr   = (state == S_IDLE) && wrEn && !start && (wrCnt < DEPTH_C);
    strb.load = (state == S_LOAD);
    strb.cmp  = (state == S_CMP);
    strb.last = (state == S_CMP) && atHi;
    // window edges, clipped without leaving the index width
    loNext = (cen >= WIN_I) ? (cen - WIN_I) : '0;
    hiNext = ((lastIdx - cen) > WIN_I) ? (cen + WIN_I) : lastIdx;
  end

  assign wrIdx   = wrCnt[IW-1:0];
  assign cenIdx  = cen;
  assign candIdx = cand;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      wrCnt   <= '0;
      lastIdx <= '0;
      cen     <= '0;
      cand    <= '0;
      hi      <= '0;
      done    <= 1'b0;
    end else begin
      done <= (state == S_FIN);
      unique case (state)
        S_IDLE: begin
          if (start) begin
            wrCnt   <= '0;
            lastIdx <= IW'(wrCnt - 1'b1);
            cen     <= '0;
            state   <= (wrCnt == '0) ? S_FIN : S_LOAD;
          end else if (strb.wr) begin
            wrCnt <= wrCnt + 1'b1;
          end
        end
        S_LOAD: begin
          cand  <= loNext;
          hi    <= hiNext;
          state <= S_CMP;
        end
        S_CMP: begin
          if (atHi) begin
            if (cen == lastIdx) begin
              state <= S_FIN;
            end else begin
              cen   <= cen + 1'b1;
              state <= S_LOAD;
            end
          end else begin
            cand <= cand + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/feat_nms_dp.sv
module feat_nms_dp
  import feat_nms_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  nms_strb_t     strb,
  input  logic [IW-1:0] wrIdx,
  input  logic [IW-1:0] cenIdx,
  input  logic [IW-1:0] candIdx,
  input  logic [XW-1:0] wrX,
  input  logic [YW-1:0] wrY,
  input  logic [SW-1:0] wrScore,
  output logic          flagValid,
  output logic [IW-1:0] flagIdx,
  output logic          flagKeep
);

  feat_t         mem [DEPTH];
  feat_t         cenF;
  feat_t         candF;
  logic [IW-1:0] cenIdxR;
  logic          keep;
  logic [XW-1:0] dx;
  logic [YW-1:0] dy;
  logic          near;
  logic          beats;
  logic          hit;

  always_ff @(posedge clk) begin
    if (strb.wr) mem[wrIdx] <= '{score: wrScore, y: wrY, x: wrX};
  end

  always_comb begin
    candF = mem[candIdx];
    dx    = (cenF.x >= candF.x) ? (cenF.x - candF.x) : (candF.x - cenF.x);
    dy    = (cenF.y >= candF.y) ? (cenF.y - candF.y) : (candF.y - cenF.y);
    near  = (dx <= XW'(1)) && (dy <= YW'(1));
    beats = (candF.score > cenF.score) ||
            ((candF.score == cenF.score) && (candIdx < cenIdxR));
    hit   = strb.cmp && (candIdx != cenIdxR) && near && beats;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cenF      <= '0;
      cenIdxR   <= '0;
      keep      <= 1'b1;
      flagValid <= 1'b0;
      flagIdx   <= '0;
      flagKeep  <= 1'b0;
    end else begin
      flagValid <= strb.last;
      if (strb.load) begin
        cenF    <= mem[cenIdx];
        cenIdxR <= cenIdx;
        keep    <= 1'b1;
      end else if (hit) begin
        keep <= 1'b0;
      end
      if (strb.last) begin
        flagIdx  <= cenIdxR;
        flagKeep <= keep & ~hit;
      end
    end
  end

endmodule

// File: rtl/feat_nms.sv
module feat_nms
  import feat_nms_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int WIN   = 20
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [XW-1:0]            wrX,
  input  logic [YW-1:0]            wrY,
  input  logic [SW-1:0]            wrScore,
  input  logic                     start,
  output logic                     flagValid,
  output logic [$clog2(DEPTH)-1:0] flagIdx,
  output logic                     flagKeep,
  output logic                     done
);

  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  nms_strb_t     strb;
  logic [IW-1:0] wrIdx;
  logic [IW-1:0] cenIdx;
  logic [IW-1:0] candIdx;

  feat_nms_ctrl #(.DEPTH(DEPTH), .WIN(WIN), .IW(IW), .CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .start(start), .strb(strb),
    .wrIdx(wrIdx), .cenIdx(cenIdx), .candIdx(candIdx), .done(done)
  );

  feat_nms_dp #(.DEPTH(DEPTH), .IW(IW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrIdx(wrIdx), .cenIdx(cenIdx),
    .candIdx(candIdx), .wrX(wrX), .wrY(wrY), .wrScore(wrScore),
    .flagValid(flagValid), .flagIdx(flagIdx), .flagKeep(flagKeep)
  );

endmodule

// File: rtl/feat_nms_chk.sv
module feat_nms_chk #(
  parameter int DEPTH = 256,
  parameter int IW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          wrEn,
  input logic          start,
  input logic          flagValid,
  input logic [IW-1:0] flagIdx,
  input logic          done
);

  logic          busyC;
  logic [CW-1:0] wrCntC;
  logic [CW-1:0] frameN;
  logic [CW-1:0] flagsSeen;
  logic          idleC;
  logic          acceptStart;
  logic          acceptWr;

  always_comb begin
    idleC       = !busyC || done;
    acceptStart = start && idleC;
    acceptWr    = wrEn && !start && idleC && (wrCntC < CW'(DEPTH));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyC     <= 1'b0;
      wrCntC    <= '0;
      frameN    <= '0;
      flagsSeen <= '0;
    end else if (acceptStart) begin
      busyC     <= 1'b1;
      frameN    <= wrCntC;
      wrCntC    <= '0;
      flagsSeen <= '0;
    end else begin
      if (done) busyC <= 1'b0;
      if (acceptWr) wrCntC <= wrCntC + 1'b1;
      if (flagValid) flagsSeen <= flagsSeen + 1'b1;
    end
  end

  // R1: nothing is presented right after reset
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !flagValid && !done);

  // R2: flags only while a scan is running
  p_flag_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    flagValid |-> busyC && !done);

  // R7: flags run 0,1,2,... in order
  p_idx_seq_r7: assert property (@(posedge clk) disable iff (!rstN)
    flagValid |-> (CW'(flagIdx) == flagsSeen));

  // R7: no more flags than stored features
  p_idx_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    flagValid |-> (flagsSeen < frameN));

  // R8: done only once every feature was flagged
  p_done_count_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busyC && (flagsSeen == frameN));

  // R8: done follows the final flag by one cycle
  p_done_follow_r8: assert property (@(posedge clk) disable iff (!rstN)
    (flagValid && (CW'(flagsSeen + 1'b1) == frameN)) |=> done);

  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

bind feat_nms feat_nms_chk #(.DEPTH(DEPTH), .IW(IW), .CW(CW)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .start(start),
  .flagValid(flagValid), .flagIdx(flagIdx), .done(done)
);

// File: tb/feat_nms_bench.sv
`timescale 1ns/1ps
module feat_nms_bench;
  import feat_nms_pkg::*;

  localparam int DEPTH = 256;
  localparam int IW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [XW-1:0] wrX = '0;
  logic [YW-1:0] wrY = '0;
  logic [SW-1:0] wrScore = '0;
  logic          start = 1'b0;
  logic          flagValid;
  logic [IW-1:0] flagIdx;
  logic          flagKeep;
  logic          done;

  feat_nms #(.DEPTH(DEPTH), .WIN(20)) u_feat_nms (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrX(wrX), .wrY(wrY),
    .wrScore(wrScore), .start(start), .flagValid(flagValid),
    .flagIdx(flagIdx), .flagKeep(flagKeep), .done(done)
  );

  always #4 clk = ~clk;  // 125 MHz

  // {x, y, score, expected keep}
  localparam logic [52:0] TAB [8] = '{
    {10'd5,   10'd5,   32'd10, 1'b0},  // R4 beaten by index 1
    {10'd6,   10'd5,   32'd20, 1'b1},  // R3 R4 strongest of group
    {10'd7,   10'd6,   32'd15, 1'b0},  // R4 beaten diagonally
    {10'd100, 10'd50,  32'd7,  1'b1},  // R3 isolated
    {10'd200, 10'd60,  32'd9,  1'b1},  // R5 tie, lower index wins
    {10'd201, 10'd61,  32'd9,  1'b0},  // R5 tie, loses
    {10'd300, 10'd100, 32'd50, 1'b1},  // R3 dy = 2 is not a neighbour
    {10'd300, 10'd102, 32'd60, 1'b1}   // R3
  };
  string tabTag [8] = '{"R4", "R4", "R4", "R3", "R5", "R5", "R3", "R3"};

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int nFlags = 0;
  int doneSeen = 0;
  int orderBad = 0;
  int lastFlagCyc = -1;
  int doneCyc = -1;
  bit gotKeep [DEPTH];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (flagValid) begin
      if (int'(flagIdx) != nFlags) orderBad++;
      gotKeep[flagIdx] = flagKeep;
      nFlags++;
      lastFlagCyc = cyc;
    end
    if (done) begin
      doneSeen++;
      doneCyc = cyc;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clearStats();
    nFlags = 0; doneSeen = 0; orderBad = 0; lastFlagCyc = -1; doneCyc = -1;
  endtask

  task automatic wrFeat(input int x, input int y, input int s);
    @(negedge clk);
    wrEn = 1'b1; wrX = XW'(x); wrY = YW'(y); wrScore = SW'(s);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic runFrame(input bit inject);
    clearStats();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (inject) begin
      // a strong neighbour written mid-scan must vanish (R9)
      @(negedge clk); wrEn = 1'b1; wrX = 10'd400; wrY = 10'd401; wrScore = 32'd999;
      @(negedge clk); wrEn = 1'b0;
    end
    for (int k = 0; k < 30000 && doneSeen == 0; k++) @(posedge clk);
    @(negedge clk);
    if (doneSeen == 0) check(1'b0, "R8 timeout", 0, 1);
  endtask

  initial begin
    #(8 * 180000);
    tests++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(flagValid == 1'b0, "R1 flagValid", int'(flagValid), 0);
    check(done == 1'b0, "R1 done", int'(done), 0);
    rstN = 1'b1;

    // table frame: stored but not started, then scanned
    clearStats();
    for (int i = 0; i < 8; i++) wrFeat(int'(TAB[i][52:43]), int'(TAB[i][42:33]), int'(TAB[i][32:1]));
    repeat (6) @(negedge clk);
    check(nFlags == 0 && doneSeen == 0, "R2 no flag before start", nFlags, 0);
    runFrame(1'b1);
    for (int i = 0; i < 8; i++)
      check(gotKeep[i] == TAB[i][0], tabTag[i], int'(gotKeep[i]), int'(TAB[i][0]));
    check(nFlags == 8, "R7 flag count", nFlags, 8);
    check(orderBad == 0, "R7 index order", orderBad, 0);
    check(doneCyc == lastFlagCyc + 1, "R8 done timing", doneCyc - lastFlagCyc, 1);

    // frame after the dropped mid-scan write
    wrFeat(400, 400, 3);
    wrFeat(401, 401, 2);
    runFrame(1'b0);
    check(nFlags == 2, "R9 stray write ignored", nFlags, 2);
    check(gotKeep[0] == 1'b1, "R9 idx0 keep", int'(gotKeep[0]), 1);
    check(gotKeep[1] == 1'b0, "R9 idx1 keep", int'(gotKeep[1]), 0);

    // window edge: neighbour 21 entries away is out of reach
    wrFeat(10, 10, 1);
    for (int i = 1; i <= 20; i++) wrFeat(100 + 5 * i, 500, 5);
    wrFeat(11, 11, 100);
    runFrame(1'b0);
    check(gotKeep[0] == 1'b1, "R6 far neighbour idx0", int'(gotKeep[0]), 1);
    check(gotKeep[21] == 1'b1, "R6 far neighbour idx21", int'(gotKeep[21]), 1);

    // window edge: neighbour 20 entries away is in reach
    wrFeat(10, 10, 1);
    for (int i = 1; i <= 19; i++) wrFeat(100 + 5 * i, 500, 5);
    wrFeat(11, 10, 50);
    runFrame(1'b0);
    check(gotKeep[0] == 1'b0, "R6 edge neighbour idx0", int'(gotKeep[0]), 0);
    check(gotKeep[20] == 1'b1, "R6 edge neighbour idx20", int'(gotKeep[20]), 1);

    // empty frame
    runFrame(1'b0);
    check(nFlags == 0, "R8 empty frame flags", nFlags, 0);
    check(doneSeen == 1, "R8 empty frame done", doneSeen, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule